// File: doc/BRIEF.md
# Cyclic Object Slot Allocator

This block hands out slots from a fixed pool of equally sized object slots that belongs to a single allocation class. Every allocation request is answered with a slot index one cycle later. The pool never grows, so the storage behind it has a fixed bound, however many allocations the client makes. When every slot has already been handed out, the allocator does not refuse the request. It reuses a slot whose object may still be live, and it raises an overlay flag so that the client can see that this happened.

Two victim policies are available, and the policy is chosen separately for each request. The round-robin policy gives out slots in plain allocation order. The least-recently-used policy picks the slot whose most recent access is the oldest. The client reports its reads and writes of slots through an access port, which keeps the recency order up to date. An explicit free port marks a slot as dead. In least-recently-used mode, a freed slot is the first one offered to the next allocation.

Top module: `cyclic_slot_alloc`

## Requirements
- R1: While reset is held and right after it is released, `grant_valid_o` and `overlay_o` are 0. The allocation counter starts at 0. The initial recency order has slot 0 as least recent, and each higher index is more recent than the one below it.
- R2: A request in cycle t gives `grant_valid_o`=1 in cycle t+1 and in no other cycle. In round-robin mode (`mode_lru_i`=0), the grant of the n-th allocation since reset (counting from 0) is slot n mod NUM_SLOTS.
- R3: Every request is granted. The granted index is always below NUM_SLOTS.
- R4: In least-recently-used mode (`mode_lru_i`=1), the granted slot is the one whose most recent access is the oldest.
- R5: An access notification (`acc_valid_i`=1, slot `acc_slot_i`) makes that slot the most recent. A slot just granted by an allocation also counts as accessed at the moment it is granted.
- R6: When an access notification and a request arrive in the same cycle, the access is applied first. As a result, a least-recently-used allocation in that cycle never picks the slot that was just accessed.
- R7: `overlay_o` is 1 together with a grant exactly when the granted slot was granted before and has not been freed since. It is 0 whenever `grant_valid_o` is 0.
- R8: A free (`free_valid_i`=1, slot `free_slot_i`) clears the slot's live state and makes it the least recent slot. The most recent free ranks first. A free in the same cycle as a request is applied before the request. A free does not change the round-robin sequence.
- R9: Access and free notifications that carry an index of NUM_SLOTS or more are ignored.
- R10: The policy is read from `mode_lru_i` in the cycle of the request. The round-robin counter advances on every allocation, in either mode. Recency is updated in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_lru_i | input | 1 | Policy for this request: 0 round-robin, 1 least recently used |
| alloc_req_i | input | 1 | Allocation request |
| acc_valid_i | input | 1 | Access notification valid |
| acc_slot_i | input | IDX_W | Slot that was read or written |
| free_valid_i | input | 1 | Free notification valid |
| free_slot_i | input | IDX_W | Slot being freed |
| grant_valid_o | output | 1 | Grant for the previous cycle's request |
| grant_slot_o | output | IDX_W | Granted slot index |
| overlay_o | output | 1 | Granted slot may still hold a live object |

## Verification
The bench builds the block with NUM_SLOTS=5. With this value the index is 3 bits wide, so the codes 5 to 7 can be driven on the access and free ports, and the out-of-range ignore rule gets exercised. Because 5 is not a power of two, a mistaken wrap at a binary boundary cannot go unseen. With such a small pool the round-robin wrap, the overlay flag and the reordering of recency all come up within a few cycles. The random phase then keeps mixing policies, same-cycle collisions and frees against a timestamp model.

// File: rtl/csa_pkg.sv
package csa_pkg;
    typedef enum logic {
        CSA_ROUND_ROBIN = 1'b0,
        CSA_LEAST_RECENT = 1'b1
    } csa_policy_e;
endpackage

// File: rtl/csa_rr_ctr.sv
module csa_rr_ctr #(
    parameter int NUM_SLOTS = 8,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [IDX_W-1:0] cnt_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

    logic [IDX_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/csa_recency.sv
module csa_recency #(
    parameter int NUM_SLOTS = 8,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_ok_i,
    input  logic [IDX_W-1:0] touch_slot_i,
    input  logic             drop_ok_i,
    input  logic [IDX_W-1:0] drop_slot_i,
    input  logic             grant_i,
    input  logic [IDX_W-1:0] grant_slot_i,
    output logic [IDX_W-1:0] victim_o
);
    localparam logic [IDX_W-1:0] TOP_RANK = IDX_W'(NUM_SLOTS - 1);

    // rank 0 = least recent, TOP_RANK = most recent; ranks form a permutation
    typedef logic [NUM_SLOTS-1:0][IDX_W-1:0] rank_t;

    rank_t rank_d, rank_q;
    rank_t rank_t1, rank_t2;

    function automatic rank_t promote(rank_t r, logic [IDX_W-1:0] s);
        rank_t o = r;
        logic [IDX_W-1:0] old = r[s];
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (r[i] > old) o[i] = r[i] - 1'b1;
        end
        o[s] = TOP_RANK;
        return o;
    endfunction

    function automatic rank_t demote(rank_t r, logic [IDX_W-1:0] s);
        rank_t o = r;
        logic [IDX_W-1:0] old = r[s];
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (r[i] < old) o[i] = r[i] + 1'b1;
        end
        o[s] = '0;
        return o;
    endfunction

    always_comb begin
        rank_t1 = rank_q;
        if (touch_ok_i) rank_t1 = promote(rank_t1, touch_slot_i);
        rank_t2 = rank_t1;
        if (drop_ok_i) rank_t2 = demote(rank_t2, drop_slot_i);
        victim_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rank_t2[i] == '0) victim_o = IDX_W'(i);
        end
        rank_d = rank_t2;
        if (grant_i) rank_d = promote(rank_t2, grant_slot_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) rank_q[i] <= IDX_W'(i);
        end else begin
            rank_q <= rank_d;
        end
    end
endmodule

// File: rtl/csa_live_map.sv
module csa_live_map #(
    parameter int NUM_SLOTS = 8,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop_ok_i,
    input  logic [IDX_W-1:0] drop_slot_i,
    input  logic             grant_i,
    input  logic [IDX_W-1:0] grant_slot_i,
    output logic             still_live_o
);
    logic [NUM_SLOTS-1:0] live_d, live_q;
    logic [NUM_SLOTS-1:0] live_f;

    always_comb begin
        live_f = live_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (drop_ok_i && drop_slot_i == IDX_W'(i)) live_f[i] = 1'b0;
        end
        still_live_o = 1'b0;
        live_d = live_f;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (grant_i && grant_slot_i == IDX_W'(i)) begin
                still_live_o = live_f[i];
                live_d[i]    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end
endmodule

// File: rtl/cyclic_slot_alloc.sv
module cyclic_slot_alloc
    import csa_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_lru_i,
    input  logic             alloc_req_i,
    input  logic             acc_valid_i,
    input  logic [IDX_W-1:0] acc_slot_i,
    input  logic             free_valid_i,
    input  logic [IDX_W-1:0] free_slot_i,
    output logic             grant_valid_o,
    output logic [IDX_W-1:0] grant_slot_o,
    output logic             overlay_o
);
    localparam logic [IDX_W:0] SLOT_LIMIT = (IDX_W + 1)'(NUM_SLOTS);

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] slot;
        logic             ovl;
    } grant_t;

    grant_t           out_d, out_q;
    csa_policy_e      policy;
    logic             acc_ok, free_ok;
    logic [IDX_W-1:0] rr_slot, lru_slot, pick_slot;
    logic             hit_live;

    assign policy  = csa_policy_e'(mode_lru_i);
    assign acc_ok  = acc_valid_i  && ({1'b0, acc_slot_i}  < SLOT_LIMIT);
    assign free_ok = free_valid_i && ({1'b0, free_slot_i} < SLOT_LIMIT);
    assign pick_slot = (policy == CSA_LEAST_RECENT) ? lru_slot : rr_slot;

    csa_rr_ctr #(.NUM_SLOTS(NUM_SLOTS)) rr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (alloc_req_i),
        .cnt_o  (rr_slot)
    );

    csa_recency #(.NUM_SLOTS(NUM_SLOTS)) rec_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .touch_ok_i   (acc_ok),
        .touch_slot_i (acc_slot_i),
        .drop_ok_i    (free_ok),
        .drop_slot_i  (free_slot_i),
        .grant_i      (alloc_req_i),
        .grant_slot_i (pick_slot),
        .victim_o     (lru_slot)
    );

    csa_live_map #(.NUM_SLOTS(NUM_SLOTS)) live_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .drop_ok_i    (free_ok),
        .drop_slot_i  (free_slot_i),
        .grant_i      (alloc_req_i),
        .grant_slot_i (pick_slot),
        .still_live_o (hit_live)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = alloc_req_i;
        out_d.ovl = alloc_req_i & hit_live;
        if (alloc_req_i) out_d.slot = pick_slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign grant_valid_o = out_q.vld;
    assign grant_slot_o  = out_q.slot;
    assign overlay_o     = out_q.ovl;
endmodule

// File: rtl/csa_checker.sv
module csa_checker #(
    parameter int NUM_SLOTS = 8,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_lru_i,
    input logic             alloc_req_i,
    input logic             acc_valid_i,
    input logic [IDX_W-1:0] acc_slot_i,
    input logic             free_valid_i,
    input logic [IDX_W-1:0] free_slot_i,
    input logic             grant_valid_o,
    input logic [IDX_W-1:0] grant_slot_o,
    input logic             overlay_o
);
    localparam logic [IDX_W:0]   LIMIT = (IDX_W + 1)'(NUM_SLOTS);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(NUM_SLOTS - 1);

    logic [IDX_W-1:0] alloc_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alloc_seen_q <= '0;
        else if (alloc_req_i) alloc_seen_q <= (alloc_seen_q == LAST) ? '0 : alloc_seen_q + 1'b1;
    end

    AST_GRANT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req_i |=> grant_valid_o); // R3
    AST_NO_SPURIOUS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_req_i |=> !grant_valid_o); // R2
    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> ({1'b0, grant_slot_o} < LIMIT)); // R3
    AST_RR_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req_i && !mode_lru_i) |=> (grant_slot_o == $past(alloc_seen_q))); // R2
    AST_OVERLAY_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid_o |-> !overlay_o); // R7
    AST_FREED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req_i && mode_lru_i && free_valid_i && ({1'b0, free_slot_i} < LIMIT))
        |=> (grant_slot_o == $past(free_slot_i) && !overlay_o)); // R8
    AST_ACCESS_BEFORE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req_i && mode_lru_i && acc_valid_i && !free_valid_i && ({1'b0, acc_slot_i} < LIMIT))
        |=> (grant_slot_o != $past(acc_slot_i))); // R6
endmodule

bind cyclic_slot_alloc csa_checker #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_lru_i    (mode_lru_i),
    .alloc_req_i   (alloc_req_i),
    .acc_valid_i   (acc_valid_i),
    .acc_slot_i    (acc_slot_i),
    .free_valid_i  (free_valid_i),
    .free_slot_i   (free_slot_i),
    .grant_valid_o (grant_valid_o),
    .grant_slot_o  (grant_slot_o),
    .overlay_o     (overlay_o)
);

// File: tb/cyclic_slot_alloc_tb_top.sv
`timescale 1ns/1ps
module cyclic_slot_alloc_tb_top;
    localparam int N  = 5;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_lru = 1'b0, alloc_req = 1'b0, acc_valid = 1'b0, free_valid = 1'b0;
    logic [IW-1:0] acc_slot = '0, free_slot = '0;
    logic          grant_valid, overlay;
    logic [IW-1:0] grant_slot;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // reference model: timestamps (smaller = older), live flags, allocation counter
    int m_ts [N];
    bit m_live [N];
    int m_cnt, m_now, m_free_base;

    always #2.5 clk = ~clk;

    cyclic_slot_alloc #(.NUM_SLOTS(N)) dut_i (
        .clk (clk), .rst_n (rst_n), .mode_lru_i (mode_lru), .alloc_req_i (alloc_req),
        .acc_valid_i (acc_valid), .acc_slot_i (acc_slot),
        .free_valid_i (free_valid), .free_slot_i (free_slot),
        .grant_valid_o (grant_valid), .grant_slot_o (grant_slot), .overlay_o (overlay)
    );

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_ts[i] = i - N;
            m_live[i] = 0;
        end
        m_cnt = 0; m_now = 0; m_free_base = -1000;
    endfunction

    function automatic int model_oldest();
        int best = 0;
        for (int i = 1; i < N; i++) if (m_ts[i] < m_ts[best]) best = i;
        return best;
    endfunction

    task automatic report(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one cycle: entered just after a negedge, returns just after the next negedge
    task automatic step(bit req, bit lru, bit av, int as, bit fv, int fs, string tag);
        int e_slot, e_ovl;
        mode_lru = lru; alloc_req = req;
        acc_valid = av; acc_slot = as[IW-1:0];
        free_valid = fv; free_slot = fs[IW-1:0];
        if (av && as < N) m_ts[as] = m_now * 4 + 1;
        if (fv && fs < N) begin
            m_ts[fs] = m_free_base; m_free_base--; m_live[fs] = 0;
        end
        e_slot = 0; e_ovl = 0;
        if (req) begin
            e_slot = lru ? model_oldest() : m_cnt;
            m_cnt = (m_cnt + 1) % N;
            e_ovl = int'(m_live[e_slot]);
            m_live[e_slot] = 1;
            m_ts[e_slot] = m_now * 4 + 3;
        end
        m_now++;
        @(posedge clk);
        @(negedge clk);
        report(tag, "grant_valid", int'(grant_valid), int'(req));
        if (req) begin
            report(tag, "grant_slot", int'(grant_slot), e_slot);
            report(tag, "overlay", int'(overlay), e_ovl);
        end else begin
            report(tag, "overlay idle", int'(overlay), 0);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; alloc_req = 0; acc_valid = 0; free_valid = 0; mode_lru = 0;
        repeat (2) @(negedge clk);
        report("R1", "grant_valid in reset", int'(grant_valid), 0);
        report("R1", "overlay in reset", int'(overlay), 0);
        rst_n = 1;
        model_reset();
        @(negedge clk);
        report("R1", "grant_valid after reset", int'(grant_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        // R1/R2: round-robin from reset, wrap at 5, overlay on second pass (R7)
        for (int k = 0; k < 7; k++) step(1, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R2");
        // R8: a free leaves round-robin order alone, clears overlay for that slot (R7)
        step(0, 0, 0, 0, 1, 2, "R8");
        for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, 0, "R7");

        do_reset();
        // R1/R4: initial LRU order slot 0 oldest
        for (int k = 0; k < 3; k++) step(1, 1, 0, 0, 0, 0, "R4");
        // R5: access 3 so slot 4 is next, then 0 again
        step(0, 1, 1, 3, 0, 0, "R5");
        step(1, 1, 0, 0, 0, 0, "R5");
        step(1, 1, 0, 0, 0, 0, "R5");
        // R6: access the current oldest in the request cycle
        step(1, 1, 1, 1, 0, 0, "R6");
        // R8: free then allocate, and free in the request cycle
        step(0, 1, 0, 0, 1, 4, "R8");
        step(1, 1, 0, 0, 0, 0, "R8");
        step(1, 1, 1, 2, 1, 2, "R8");
        // R9: out-of-range access and free are ignored
        step(0, 1, 1, 6, 1, 7, "R9");
        step(1, 1, 1, 5, 1, 5, "R9");
        step(1, 1, 0, 0, 0, 0, "R9");
        // R10: mode changes per request, counter advanced in both modes
        step(1, 0, 0, 0, 0, 0, "R10");
        step(1, 1, 0, 0, 0, 0, "R10");
        step(1, 0, 0, 0, 0, 0, "R10");

        do_reset();
        // R3: random mix, every request granted in range
        for (int k = 0; k < 4000; k++) begin
            bit r  = ($urandom % 10) < 6;
            bit l  = $urandom % 2;
            bit av = ($urandom % 10) < 4;
            bit fv = ($urandom % 20) < 3;
            step(r, l, av, int'($urandom % 8), fv, int'($urandom % 8), "R3");
        end

        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule